// File: doc/BRIEF.md
# Vectored interrupt priority nesting engine

This block decides which interrupt handler runs next and keeps track of how deeply handlers are nested. It holds sixteen programmable vector slots and one default vector. Each slot has a handler address and a control byte. The control byte enables the slot and names which of the 32 interrupt sources the slot serves. The slot number is its priority: slot 0 outranks slot 1, and so on. A seventeenth level, the default level 16, catches any pending source that no enabled slot serves. A final idle level 17 means that no handler is running.

When software reads the vector register, the engine searches every level that outranks the current one for a pending source. The winner becomes the current level. The engine records the level it came from in a per-level record and returns the winner's handler address. When software writes the vector register, the engine returns to the recorded level. The current level selects a priority mask, and the mask gates the IRQ request. While a handler runs, only sources served by higher-priority slots can interrupt it.

The nesting control is a small operation decoder with five named operations, selected each cycle from the bus access and the search result:
- VOP_NONE: no access to the vector register; the level holds.
- VOP_GRANT: a read found a winner; the level descends to the winner.
- VOP_DEFAULT: a read found no winner; the level holds.
- VOP_RESTORE: a write while a level is active; the level returns to the recorded one.
- VOP_IDLE_WR: a write while idle; the level holds.

Top module: `vic_nest_engine`

## Requirements
- R1: After reset the current level is 17 (idle), every slot address, slot control byte and the default address read back as 0, the priority mask is all ones and rdata is 0.
- R2: Slot k's 32-bit address is at byte offset 0x100+4k and its control byte at 0x200+4k (read back zero-extended, upper bits 0). The default address is at 0x34. A read returns its value on rdata from the clock edge that samples rd_en, and rdata holds until the next read. A read of any other offset returns 0.
- R3: For a level L from 0 to 16, the priority mask is the OR of (1 << ctrl[4:0]) over every slot j < L whose control bit 5 is set. For level 17 the mask is all ones. prio_mask shows the mask of the current level and reflects a control write from the cycle after the write.
- R4: irq_req is 1 exactly when (irq_src & prio_mask) is non-zero.
- R5: A read of offset 0x30 finds the winner: the smallest level L below the current level such that either L < 16 and slot L is enabled with its source pending, or L = 16 and any pend_src bit is set. The read returns slot L's address (the default address when L = 16), and the level becomes L after the edge.
- R6: A read of 0x30 that finds no winner returns the default address and leaves the level unchanged.
- R7: A write to 0x30 ignores its data. If the level is not 17, the level returns to the one that was current when that level was granted. At level 17 the write has no effect on the level.
- R8: Grants nest: successive grants descend through levels, and successive writes to 0x30 unwind them in reverse order back to idle.
- R9: If several slots are pending, or several slots serve the same source, the lowest-numbered enabled slot wins. A disabled slot (bit 5 clear) never wins, so its source falls to the default level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (never with wr_en) |
| addr | input | 12 | Byte offset of the access |
| wdata | input | 32 | Write data |
| pend_src | input | 32 | Pending sources, raw or software-raised |
| irq_src | input | 32 | Pending sources that are enabled and routed to IRQ |
| rdata | output | 32 | Registered read data |
| prio_mask | output | 32 | Mask of sources that may interrupt the current level |
| irq_req | output | 1 | IRQ request after priority masking |
| cur_level | output | 5 | Current priority level (17 = idle) |

## Verification
The vector register is exercised in several ways. A single pending source tells a correct slot lookup apart from an off-by-one level. Two pending sources, where the second outranks the first, show both nesting and the mask that admits the second. A source served by two slots, and a source served only by a disabled slot, show the lowest-slot rule and the fall-through to the default level. Reads with nothing pending above the current level, and writes while idle, show that the level holds. A long phase of mixed random reads, writes, control rewrites and changing source patterns is checked against a stack-based model on every clock, which catches unwinding order and stale masks.

// File: rtl/vic_nest_pkg.sv
package vic_nest_pkg;

    // Default geometry of the engine.
    localparam int VIC_SLOTS = 16;
    localparam int VIC_SRCS  = 32;
    localparam int VIC_DW    = 32;
    localparam int VIC_AW    = 12;

    // Byte offsets decoded by the engine.
    localparam logic [11:0] OFS_VEC       = 12'h030;
    localparam logic [11:0] OFS_DEF       = 12'h034;
    localparam logic [11:0] OFS_SLOT_ADDR = 12'h100;
    localparam logic [11:0] OFS_SLOT_CTRL = 12'h200;

    // Control byte layout: enable flag above the source number.
    localparam int CTRL_W      = 8;
    localparam int CTRL_EN_BIT = 5;

    // Operation performed on the nesting state in a given cycle.
    typedef enum logic [2:0] {
        VOP_NONE,
        VOP_GRANT,
        VOP_DEFAULT,
        VOP_RESTORE,
        VOP_IDLE_WR
    } vec_op_e;

endpackage

// File: rtl/vic_slot_regs.sv
module vic_slot_regs
    import vic_nest_pkg::*;
#(
    parameter int NSLOT = VIC_SLOTS,
    parameter int DW    = VIC_DW,
    parameter int AW    = VIC_AW
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [AW-1:0]                 addr,
    input  logic [DW-1:0]                 wdata,
    output logic [NSLOT-1:0][DW-1:0]      slot_addr,
    output logic [NSLOT-1:0][CTRL_W-1:0]  slot_ctrl,
    output logic [DW-1:0]                 def_addr,
    output logic [DW-1:0]                 reg_rdata
);

    logic [NSLOT-1:0] addr_hit;
    logic [NSLOT-1:0] ctrl_hit;
    logic             def_hit;

    assign def_hit = (addr == AW'(OFS_DEF));

    // One word per slot in each of the two regions.
    for (genvar k = 0; k < NSLOT; k++) begin : g_dec
        assign addr_hit[k] = (addr == AW'(OFS_SLOT_ADDR + 4 * k));
        assign ctrl_hit[k] = (addr == AW'(OFS_SLOT_CTRL + 4 * k));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_addr <= '0;
            slot_ctrl <= '0;
        end else if (wr_en) begin
            for (int k = 0; k < NSLOT; k++) begin
                if (addr_hit[k]) slot_addr[k] <= wdata;
                if (ctrl_hit[k]) slot_ctrl[k] <= wdata[CTRL_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            def_addr <= '0;
        end else if (wr_en && def_hit) begin
            def_addr <= wdata;
        end
    end

    // Readback of the plain storage; unmapped offsets give zero.
    always_comb begin
        reg_rdata = '0;
        if (def_hit) reg_rdata = def_addr;
        for (int k = 0; k < NSLOT; k++) begin
            if (addr_hit[k]) reg_rdata = slot_addr[k];
            if (ctrl_hit[k]) reg_rdata = DW'(slot_ctrl[k]);
        end
    end

    p_ctrl_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ctrl_hit[0]) |=> (slot_ctrl[0] == $past(wdata[CTRL_W-1:0])));

    p_def_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && def_hit) |=> (def_addr == $past(wdata)));

endmodule

// File: rtl/vic_mask_gen.sv
module vic_mask_gen
    import vic_nest_pkg::*;
#(
    parameter int NSLOT = VIC_SLOTS,
    parameter int NSRC  = VIC_SRCS
) (
    input  logic [NSLOT-1:0][CTRL_W-1:0] slot_ctrl,
    output logic [NSLOT-1:0][NSRC-1:0]   slot_hot,
    output logic [NSLOT+1:0][NSRC-1:0]   lvl_mask
);

    localparam int SRCW = $clog2(NSRC);

    // Only the enable flag and the source field steer the masks.
    logic ctrl_unused;
    assign ctrl_unused = ^slot_ctrl;

    // Level 0 is outranked by nothing.
    assign lvl_mask[0] = '0;

    // Each level adds the source of the slot just above it.
    for (genvar k = 0; k < NSLOT; k++) begin : g_lvl
        logic [SRCW-1:0] src;
        assign src         = slot_ctrl[k][SRCW-1:0];
        assign slot_hot[k] = slot_ctrl[k][CTRL_EN_BIT] ? (NSRC'(1) << src) : '0;
        assign lvl_mask[k+1] = lvl_mask[k] | slot_hot[k];
    end

    // Idle level lets every source through.
    assign lvl_mask[NSLOT+1] = '1;

endmodule

// File: rtl/vic_level_stack.sv
module vic_level_stack
    import vic_nest_pkg::*;
#(
    parameter int NSLOT = VIC_SLOTS,
    parameter int NSRC  = VIC_SRCS,
    parameter int DW    = VIC_DW,
    parameter int LVLW  = $clog2(NSLOT + 2)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        vec_rd,
    input  logic                        vec_wr,
    input  logic [NSRC-1:0]             pend_src,
    input  logic [NSLOT-1:0][NSRC-1:0]  slot_hot,
    input  logic [NSLOT-1:0][DW-1:0]    slot_addr,
    input  logic [DW-1:0]               def_addr,
    output logic [LVLW-1:0]             cur_level,
    output logic [DW-1:0]               vec_rdata
);

    localparam int                SLW      = $clog2(NSLOT);
    localparam logic [LVLW-1:0]   DEF_LVL  = LVLW'(NSLOT);
    localparam logic [LVLW-1:0]   IDLE_LVL = LVLW'(NSLOT + 1);

    logic                        found;
    logic [LVLW-1:0]             win;
    vec_op_e                     op;
    logic [LVLW-1:0]             nxt_level;
    logic [NSLOT:0][LVLW-1:0]    prev_lvl;

    // Search the levels that outrank the current one, highest first.
    always_comb begin
        found = 1'b0;
        win   = DEF_LVL;
        for (int l = 0; l < NSLOT; l++) begin
            if (!found && (LVLW'(l) < cur_level) && (|(pend_src & slot_hot[l]))) begin
                found = 1'b1;
                win   = LVLW'(l);
            end
        end
        if (!found && (DEF_LVL < cur_level) && (|pend_src)) begin
            found = 1'b1;
            win   = DEF_LVL;
        end
    end

    // Operation decode for this cycle.
    always_comb begin
        if (vec_wr) begin
            op = (cur_level == IDLE_LVL) ? VOP_IDLE_WR : VOP_RESTORE;
        end else if (vec_rd) begin
            op = found ? VOP_GRANT : VOP_DEFAULT;
        end else begin
            op = VOP_NONE;
        end
    end

    // Next level and returned vector for each operation.
    always_comb begin
        nxt_level = cur_level;
        vec_rdata = def_addr;
        unique case (op)
            VOP_NONE:    nxt_level = cur_level;
            VOP_GRANT: begin
                nxt_level = win;
                vec_rdata = (win == DEF_LVL) ? def_addr : slot_addr[win[SLW-1:0]];
            end
            VOP_DEFAULT: nxt_level = cur_level;
            VOP_RESTORE: nxt_level = prev_lvl[cur_level];
            VOP_IDLE_WR: nxt_level = cur_level;
            default:     nxt_level = cur_level;
        endcase
    end

    // Level register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_level <= IDLE_LVL;
        end else begin
            cur_level <= nxt_level;
        end
    end

    // Per-level record of the level to return to, written on grant only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int l = 0; l <= NSLOT; l++) prev_lvl[l] <= IDLE_LVL;
        end else if (op == VOP_GRANT) begin
            prev_lvl[win] <= cur_level;
        end
    end

    p_level_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cur_level <= IDLE_LVL);

    p_grant_deeper_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == VOP_GRANT) |=> (cur_level < $past(cur_level)));

    p_nogrant_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_rd && !vec_wr && !found) |=> $stable(cur_level));

    p_idle_write_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_wr && cur_level == IDLE_LVL) |=> (cur_level == IDLE_LVL));

    p_restore_up_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_wr && cur_level != IDLE_LVL) |=> (cur_level > $past(cur_level)));

endmodule

// File: rtl/vic_nest_engine.sv
module vic_nest_engine
    import vic_nest_pkg::*;
#(
    parameter int NSLOT = VIC_SLOTS,
    parameter int NSRC  = VIC_SRCS,
    parameter int DW    = VIC_DW,
    parameter int AW    = VIC_AW,
    parameter int LVLW  = $clog2(NSLOT + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    input  logic [NSRC-1:0]   pend_src,
    input  logic [NSRC-1:0]   irq_src,
    output logic [DW-1:0]     rdata,
    output logic [NSRC-1:0]   prio_mask,
    output logic              irq_req,
    output logic [LVLW-1:0]   cur_level
);

    localparam logic [LVLW-1:0] IDLE_LVL = LVLW'(NSLOT + 1);

    logic                         vec_hit;
    logic                         vec_rd;
    logic                         vec_wr;
    logic [NSLOT-1:0][DW-1:0]     slot_addr;
    logic [NSLOT-1:0][CTRL_W-1:0] slot_ctrl;
    logic [DW-1:0]                def_addr;
    logic [DW-1:0]                reg_rdata;
    logic [DW-1:0]                vec_rdata;
    logic [NSLOT-1:0][NSRC-1:0]   slot_hot;
    logic [NSLOT+1:0][NSRC-1:0]   lvl_mask;

    assign vec_hit = (addr == AW'(OFS_VEC));
    assign vec_rd  = rd_en & vec_hit;
    assign vec_wr  = wr_en & vec_hit;

    vic_slot_regs #(
        .NSLOT (NSLOT),
        .DW    (DW),
        .AW    (AW)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .slot_addr (slot_addr),
        .slot_ctrl (slot_ctrl),
        .def_addr  (def_addr),
        .reg_rdata (reg_rdata)
    );

    vic_mask_gen #(
        .NSLOT (NSLOT),
        .NSRC  (NSRC)
    ) u_masks (
        .slot_ctrl (slot_ctrl),
        .slot_hot  (slot_hot),
        .lvl_mask  (lvl_mask)
    );

    vic_level_stack #(
        .NSLOT (NSLOT),
        .NSRC  (NSRC),
        .DW    (DW),
        .LVLW  (LVLW)
    ) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .vec_rd    (vec_rd),
        .vec_wr    (vec_wr),
        .pend_src  (pend_src),
        .slot_hot  (slot_hot),
        .slot_addr (slot_addr),
        .def_addr  (def_addr),
        .cur_level (cur_level),
        .vec_rdata (vec_rdata)
    );

    // Registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= vec_hit ? vec_rdata : reg_rdata;
        end
    end

    assign prio_mask = lvl_mask[cur_level];
    assign irq_req   = |(irq_src & prio_mask);

    p_idle_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_level == IDLE_LVL) |-> (&prio_mask));

    p_top_level_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_level == '0) |-> !irq_req);

    p_vec_read_default_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_rd && $stable(cur_level) && cur_level == '0) |=> (rdata == $past(def_addr)));

endmodule

// File: tb/vic_nest_engine_bench.sv
`timescale 1ns/1ps
module vic_nest_engine_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en, rd_en;
    logic [11:0] addr;
    logic [31:0] wdata, pend_src, irq_src;
    logic [31:0] rdata, prio_mask;
    logic        irq_req;
    logic [4:0]  cur_level;

    always #2.5 clk = ~clk;

    vic_nest_engine u_vic_nest_engine (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .pend_src(pend_src), .irq_src(irq_src), .rdata(rdata),
        .prio_mask(prio_mask), .irq_req(irq_req), .cur_level(cur_level)
    );

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Behavioural reference state.
    logic [31:0] m_addr [16];
    logic [7:0]  m_ctrl [16];
    logic [31:0] m_def, m_rdata;
    int          m_cur;
    int          m_stk[$];

    function automatic logic [31:0] m_mask(int lvl);
        logic [31:0] m = 32'h0;
        if (lvl == 17) return 32'hFFFF_FFFF;
        for (int j = 0; j < lvl; j++)
            if (m_ctrl[j][5]) m[m_ctrl[j][4:0]] = 1'b1;
        return m;
    endfunction

    function automatic int m_winner();
        for (int l = 0; l < 16; l++)
            if (l < m_cur && m_ctrl[l][5] && pend_src[m_ctrl[l][4:0]]) return l;
        if (16 < m_cur && pend_src != 0) return 16;
        return -1;
    endfunction

    task automatic model_edge();
        int w;
        if (!rst_n) begin
            for (int k = 0; k < 16; k++) begin m_addr[k] = 0; m_ctrl[k] = 0; end
            m_def = 0; m_rdata = 0; m_cur = 17; m_stk.delete();
        end else begin
            if (wr_en) begin
                if (addr >= 12'h100 && addr < 12'h140 && addr[1:0] == 0) m_addr[(addr - 12'h100) >> 2] = wdata;
                if (addr >= 12'h200 && addr < 12'h240 && addr[1:0] == 0) m_ctrl[(addr - 12'h200) >> 2] = wdata[7:0];
                if (addr == 12'h034) m_def = wdata;
                if (addr == 12'h030 && m_cur != 17) m_cur = m_stk.pop_back();
            end
            if (rd_en) begin
                m_rdata = 0;
                if (addr >= 12'h100 && addr < 12'h140 && addr[1:0] == 0) m_rdata = m_addr[(addr - 12'h100) >> 2];
                if (addr >= 12'h200 && addr < 12'h240 && addr[1:0] == 0) m_rdata = {24'h0, m_ctrl[(addr - 12'h200) >> 2]};
                if (addr == 12'h034) m_rdata = m_def;
                if (addr == 12'h030) begin
                    w = m_winner();
                    if (w < 0) m_rdata = m_def;
                    else begin
                        m_stk.push_back(m_cur);
                        m_cur = w;
                        m_rdata = (w == 16) ? m_def : m_addr[w];
                    end
                end
            end
        end
    endtask

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One clock: model follows the edge, outputs compared at the falling edge.
    task automatic cyc(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk(tag, "cur_level", {27'h0, cur_level}, m_cur);
        chk("R3", "prio_mask", prio_mask, m_mask(m_cur));
        chk("R4", "irq_req", {31'h0, irq_req}, {31'h0, |(irq_src & m_mask(m_cur))});
        chk(tag, "rdata", rdata, m_rdata);
    endtask

    task automatic op(input string tag, input bit w, input bit r, input logic [11:0] a, input logic [31:0] d);
        wr_en = w; rd_en = r; addr = a; wdata = d;
        cyc(tag);
        wr_en = 0; rd_en = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 0; wr_en = 0; rd_en = 0; addr = 0; wdata = 0; pend_src = 0; irq_src = 0;
        @(negedge clk);
        repeat (3) cyc("R1");
        rst_n = 1;
        cyc("R1");
        op("R1", 0, 1, 12'h104, 0);
        op("R1", 0, 1, 12'h208, 0);
        op("R1", 0, 1, 12'h034, 0);

        // Program slots: slot0 src5, slot1 src3, slot2 disabled src7, slot3 src5 again, slot15 src31.
        for (int k = 0; k < 16; k++) op("R2", 1, 0, 12'h100 + 12'(4 * k), 32'h1000_0000 + 32'(k * 16));
        op("R2", 1, 0, 12'h200, 32'hFFFF_FF25);
        op("R2", 1, 0, 12'h204, 32'h23);
        op("R2", 1, 0, 12'h208, 32'h07);
        op("R2", 1, 0, 12'h20C, 32'h25);
        op("R2", 1, 0, 12'h23C, 32'h3F);
        op("R2", 1, 0, 12'h034, 32'hDEAD_0000);
        op("R2", 0, 1, 12'h200, 0);
        chk("R2", "ctrl zero-extended", rdata, 32'h25);
        op("R2", 0, 1, 12'h13C, 0);
        op("R2", 0, 1, 12'h008, 0);
        chk("R2", "unmapped read", rdata, 0);

        // Idle mask admits everything.
        irq_src = 32'h80; cyc("R4");

        // Single pending source served by slot1.
        pend_src = 32'h8; irq_src = 32'h8;
        op("R5", 0, 1, 12'h030, 0);
        chk("R5", "grant slot1", {27'h0, cur_level}, 1);
        chk("R5", "slot1 vector", rdata, 32'h1000_0010);
        irq_src = 32'h20; cyc("R4");

        // Higher-priority source nests.
        pend_src = 32'h28;
        op("R8", 0, 1, 12'h030, 0);
        chk("R8", "nested level", {27'h0, cur_level}, 0);
        op("R6", 0, 1, 12'h030, 0);
        chk("R6", "no winner default", rdata, 32'hDEAD_0000);
        op("R7", 1, 0, 12'h030, 32'h1234_5678);
        chk("R8", "unwind one", {27'h0, cur_level}, 1);
        op("R7", 1, 0, 12'h030, 32'hFFFF_FFFF);
        chk("R8", "unwind to idle", {27'h0, cur_level}, 17);
        op("R7", 1, 0, 12'h030, 0);
        chk("R7", "idle write holds", {27'h0, cur_level}, 17);

        // Disabled slot's source falls to default; duplicate source picks slot0.
        pend_src = 32'h80;
        op("R9", 0, 1, 12'h030, 0);
        chk("R9", "default level", {27'h0, cur_level}, 16);
        op("R2", 1, 0, 12'h210, 32'h29);
        irq_src = 32'h200; cyc("R3");
        pend_src = 32'h20;
        op("R9", 0, 1, 12'h030, 0);
        chk("R9", "lowest slot wins", rdata, 32'h1000_0000);
        op("R7", 1, 0, 12'h030, 0);
        op("R7", 1, 0, 12'h030, 0);

        // Nothing pending at idle.
        pend_src = 0;
        op("R6", 0, 1, 12'h030, 0);
        chk("R6", "idle empty read", {27'h0, cur_level}, 17);

        // Last slot.
        pend_src = 32'h8000_0000;
        op("R5", 0, 1, 12'h030, 0);
        chk("R5", "slot15 vector", rdata, 32'h1000_00F0);
        op("R6", 0, 1, 12'h030, 0);
        op("R7", 1, 0, 12'h030, 0);

        // Mixed traffic against the model.
        for (int i = 0; i < 600; i++) begin
            int unsigned sel = $urandom % 8;
            case (sel)
                0, 1: op("R5", 0, 1, 12'h030, 0);
                2:    op("R7", 1, 0, 12'h030, $urandom);
                3:    op("R3", 1, 0, 12'h200 + 12'(4 * ($urandom % 16)), $urandom);
                4:    op("R2", 0, 1, 12'h200 + 12'(4 * ($urandom % 16)), 0);
                5:    begin pend_src = (32'h1 << ($urandom % 32)) | (32'h1 << ($urandom % 32)); cyc("R9"); end
                6:    begin irq_src = $urandom & $urandom; cyc("R4"); end
                default: op("R8", 0, 1, 12'h030, 0);
            endcase
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule